// File: doc/BRIEF.md
# Byte-Lane Multi-Cycle Memory Port

This block is the memory side of a small 16-bit processor whose addresses count bytes. The requester raises an access enable, picks read or write and word or byte size, and holds the address and store value steady. The port then waits a fixed number of clock cycles. A small counter that the requester can see shows how far the wait has gone, and a ready flag marks the one cycle in which the access completes.

Storage is a pair of byte-wide arrays, one for each byte lane, so a byte store changes only the lane picked by the low address bit. Word accesses drop that bit. For loads, the port returns the raw 16-bit word and also a value ready for the destination register: the whole word for a word load, or the addressed byte sign-extended to 16 bits for a byte load.

Top module: `bytelane_mem_port`

## Requirements
- R1: A synchronous reset clears the wait counter to 0, and afterwards ready, we_lo and we_hi are low. This holds even when reset arrives in the middle of an access.
- R2: While mem_en is high, wait_cnt steps 0, 1, ..., LATENCY-1, one step per clock. ready is high exactly in the cycle where wait_cnt = LATENCY-1 and mem_en is high, which is the fifth enabled cycle for the default LATENCY = 5.
- R3: wait_cnt goes back to 0 in the cycle after ready, even if mem_en stays high. It also goes to 0 in any cycle that follows a cycle with mem_en low, so dropping mem_en part way through abandons the access.
- R4: Word accesses ignore addr[0], and the word index is addr[IDX_W:1]. Address bits above IDX_W are ignored, so addresses that differ only in those bits reach the same word.
- R5: A word store (wr_sel = 1, size_byte = 0) raises we_lo and we_hi together, and only in the ready cycle. Its wbus equals wdata.
- R6: A byte store with addr[0] = 1 raises only we_hi. It places wdata[7:0] on wbus[15:8] with wbus[7:0] = 0, and the low byte of that word keeps its old value.
- R7: A byte store with addr[0] = 0 raises only we_lo. It places wdata[7:0] on wbus[7:0] with wbus[15:8] = 0, and the high byte keeps its old value.
- R8: In the ready cycle of a read, rdata is the stored word. load_ext is that word for a word load. For a byte load it is the byte selected by addr[0] (1 = bits [15:8], 0 = bits [7:0]), sign-extended from its bit 7.
- R9: rdata and load_ext are 0 in every cycle except the ready cycle of a read. we_lo and we_hi are low during reads, in cycles with mem_en low, and in cycles before the ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Access enable, held high for the whole access |
| wr_sel | input | 1 | 1 = store, 0 = load |
| size_byte | input | 1 | 1 = byte access, 0 = word access |
| addr | input | 16 | Byte address |
| wdata | input | 16 | Store value (a byte store uses bits [7:0]) |
| we_lo | output | 1 | Write enable for the low byte lane, bits [7:0] |
| we_hi | output | 1 | Write enable for the high byte lane, bits [15:8] |
| wbus | output | 16 | Lane-steered store data, 0 unless a store is enabled |
| rdata | output | 16 | Raw stored word, valid in the read ready cycle, else 0 |
| load_ext | output | 16 | Value for the destination register: the word, or the sign-extended byte |
| ready | output | 1 | Access completes in this cycle |
| wait_cnt | output | 3 | Visible wait counter (width is the ceiling of log2 of LATENCY) |

## Verification
The bench builds the port with LATENCY = 5 and IDX_W = 4, so the array holds 16 words. With 16 words, an address that differs only in bit 5 lands on the same word, which lets the bench check the address aliasing of R4 with one extra read. Each access is checked cycle by cycle across all five wait cycles, and byte stores are checked to both lanes followed by word and byte reads of the merged result. Directed runs cover a reset in the middle of an access, an access abandoned by dropping the enable, and back-to-back accesses with the enable held high.

// File: rtl/mem_port_pkg.sv
package mem_port_pkg;
  localparam int LANE_W = 8;
  localparam int WORD_W = 16;
  localparam int NLANES = WORD_W / LANE_W;

  function automatic logic [WORD_W-1:0] sext_lane(input logic [LANE_W-1:0] b);
    return {{(WORD_W-LANE_W){b[LANE_W-1]}}, b};
  endfunction
endpackage

// File: rtl/mem_wait_ctr.sv
module mem_wait_ctr #(
  parameter int LATENCY = 5,
  localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          done,
  output logic          launch
);
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);
  localparam logic [CW-1:0] PRE  = CW'(LATENCY - 2);

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (!en)              cnt <= '0;
    else if (cnt == LAST)      cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // done: last wait cycle; launch: one cycle earlier, starts the array read
  assign done   = en && (cnt == LAST);
  assign launch = en && (cnt == PRE);
endmodule

// File: rtl/mem_lane_steer.sv
module mem_lane_steer
  import mem_port_pkg::*;
(
  input  logic                active,
  input  logic                done,
  input  logic                wr,
  input  logic                is_byte,
  input  logic                odd,
  input  logic [WORD_W-1:0]   wdata,
  output logic [NLANES-1:0]   we,
  output logic [WORD_W-1:0]   wbus
);
  logic [NLANES-1:0] lane_sel;
  logic [WORD_W-1:0] steered;

  always_comb begin
    if (!is_byte) begin
      lane_sel = '1;
      steered  = wdata;
    end else if (odd) begin
      lane_sel = 2'b10;
      steered  = {wdata[LANE_W-1:0], {LANE_W{1'b0}}};
    end else begin
      lane_sel = 2'b01;
      steered  = {{LANE_W{1'b0}}, wdata[LANE_W-1:0]};
    end
  end

  assign we   = (done && wr) ? lane_sel : '0;
  assign wbus = (active && wr) ? steered : '0;
endmodule

// File: rtl/mem_lane_ram.sv
module mem_lane_ram
  import mem_port_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                clk,
  input  logic                rd_en,
  input  logic [NLANES-1:0]   we,
  input  logic [IDX_W-1:0]    idx,
  input  logic [WORD_W-1:0]   wbus,
  output logic [WORD_W-1:0]   q
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g])  arr[idx] <= wbus[g*LANE_W +: LANE_W];
      if (rd_en)  q[g*LANE_W +: LANE_W] <= arr[idx];
    end
  end
endmodule

// File: rtl/bytelane_mem_port.sv
module bytelane_mem_port
  import mem_port_pkg::*;
#(
  parameter int LATENCY = 5,
  parameter int IDX_W   = 4,
  localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_en,
  input  logic          wr_sel,
  input  logic          size_byte,
  input  logic [15:0]   addr,
  input  logic [15:0]   wdata,
  output logic          we_lo,
  output logic          we_hi,
  output logic [15:0]   wbus,
  output logic [15:0]   rdata,
  output logic [15:0]   load_ext,
  output logic          ready,
  output logic [CW-1:0] wait_cnt
);
  logic              done, launch;
  logic [NLANES-1:0] we;
  logic [WORD_W-1:0] q;
  logic [LANE_W-1:0] sel_byte;
  logic              show;

  mem_wait_ctr #(.LATENCY(LATENCY)) u_ctr (
    .clk(clk), .rst(rst), .en(mem_en),
    .cnt(wait_cnt), .done(done), .launch(launch)
  );

  mem_lane_steer u_steer (
    .active(mem_en), .done(done), .wr(wr_sel), .is_byte(size_byte),
    .odd(addr[0]), .wdata(wdata), .we(we), .wbus(wbus)
  );

  // word index drops address bit 0
  mem_lane_ram #(.IDX_W(IDX_W)) u_ram (
    .clk(clk), .rd_en(launch && !wr_sel), .we(we),
    .idx(addr[IDX_W:1]), .wbus(wbus), .q(q)
  );

  assign we_lo    = we[0];
  assign we_hi    = we[1];
  assign ready    = done;
  assign show     = done && !wr_sel;
  assign sel_byte = addr[0] ? q[WORD_W-1 -: LANE_W] : q[LANE_W-1:0];
  assign rdata    = show ? q : '0;
  assign load_ext = !show     ? '0 :
                    size_byte ? sext_lane(sel_byte) : q;
endmodule

module bytelane_mem_port_chk #(
  parameter int LATENCY = 5,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_en,
  input logic          wr_sel,
  input logic          size_byte,
  input logic          addr0,
  input logic          we_lo,
  input logic          we_hi,
  input logic          ready,
  input logic [15:0]   rdata,
  input logic [CW-1:0] wait_cnt
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (wait_cnt == '0));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !ready) |=> (wait_cnt == $past(wait_cnt) + 1'b1));
  // R3
  wrap_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> (wait_cnt == '0));
  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_en |=> (wait_cnt == '0));
  // R5
  we_only_store_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (we_lo || we_hi) |-> (ready && wr_sel && mem_en));
  // R5
  word_both_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && wr_sel && !size_byte) |-> (we_lo && we_hi));
  // R6
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (size_byte && (we_lo || we_hi)) |-> ($onehot({we_hi, we_lo}) && (we_hi == addr0)));
  // R9
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready || wr_sel) |-> (rdata == '0));
endmodule

bind bytelane_mem_port bytelane_mem_port_chk #(.LATENCY(LATENCY), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .mem_en(mem_en), .wr_sel(wr_sel), .size_byte(size_byte),
  .addr0(addr[0]), .we_lo(we_lo), .we_hi(we_hi), .ready(ready),
  .rdata(rdata), .wait_cnt(wait_cnt)
);

// File: tb/sim_bytelane_mem_port.sv
module sim_bytelane_mem_port;
  localparam int LAT = 5;
  localparam int IW  = 4;
  localparam int CW  = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic mem_en = 1'b0, wr_sel = 1'b0, size_byte = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic we_lo, we_hi, ready;
  logic [15:0] wbus, rdata, load_ext;
  logic [CW-1:0] wait_cnt;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bytelane_mem_port #(.LATENCY(LAT), .IDX_W(IW)) u0 (
    .clk(clk), .rst(rst), .mem_en(mem_en), .wr_sel(wr_sel), .size_byte(size_byte),
    .addr(addr), .wdata(wdata), .we_lo(we_lo), .we_hi(we_hi), .wbus(wbus),
    .rdata(rdata), .load_ext(load_ext), .ready(ready), .wait_cnt(wait_cnt)
  );

  typedef struct packed {
    logic        wr;
    logic        byt;
    logic [15:0] a;
    logic [15:0] wd;
    logic [15:0] exp_rd;
    logic [15:0] exp_ext;
    logic [3:0]  req;
  } vec_t;

  // write vectors: R5 word, R6/R7 byte lanes; reads: R4 alignment/alias, R8 formatting
  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b0, 16'h0010, 16'hA5C3, 16'h0000, 16'h0000, 4'd5},
    '{1'b1, 1'b0, 16'h0013, 16'h1234, 16'h0000, 16'h0000, 4'd4},
    '{1'b0, 1'b0, 16'h0011, 16'h0000, 16'hA5C3, 16'hA5C3, 4'd4},
    '{1'b0, 1'b0, 16'h0012, 16'h0000, 16'h1234, 16'h1234, 4'd4},
    '{1'b1, 1'b1, 16'h0013, 16'h77F0, 16'h0000, 16'h0000, 4'd6},
    '{1'b1, 1'b1, 16'h0010, 16'h0081, 16'h0000, 16'h0000, 4'd7},
    '{1'b0, 1'b0, 16'h0012, 16'h0000, 16'hF034, 16'hF034, 4'd6},
    '{1'b0, 1'b1, 16'h0013, 16'h0000, 16'hF034, 16'hFFF0, 4'd8},
    '{1'b0, 1'b1, 16'h0012, 16'h0000, 16'hF034, 16'h0034, 4'd8},
    '{1'b0, 1'b1, 16'h0010, 16'h0000, 16'hA581, 16'hFF81, 4'd7},
    '{1'b0, 1'b1, 16'h0011, 16'h0000, 16'hA581, 16'hFFA5, 4'd8},
    '{1'b0, 1'b0, 16'h0030, 16'h0000, 16'hA581, 16'hA581, 4'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic access(input vec_t v);
    logic [1:0]  exp_we;
    logic [15:0] exp_bus;
    string tag;
    tag = $sformatf("R%0d", v.req);
    exp_we  = !v.wr ? 2'b00 : (!v.byt ? 2'b11 : (v.a[0] ? 2'b10 : 2'b01));
    exp_bus = !v.wr ? 16'h0 : (!v.byt ? v.wd :
              (v.a[0] ? {v.wd[7:0], 8'h00} : {8'h00, v.wd[7:0]}));
    @(negedge clk);
    mem_en = 1'b1; wr_sel = v.wr; size_byte = v.byt; addr = v.a; wdata = v.wd;
    for (int k = 0; k < LAT; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      chk("R2 count", 32'(wait_cnt), k);
      if (k < LAT-1) begin
        chk("R2 early ready", 32'(ready), 0);
        chk("R9 early we", {we_hi, we_lo}, 0);
        chk("R9 early rdata", {rdata, load_ext}, 0);
      end else begin
        chk("R2 ready", 32'(ready), 1);
        chk({tag, " we"}, {we_hi, we_lo}, exp_we);
        if (v.wr) begin
          chk({tag, " wbus"}, wbus, exp_bus);
          chk("R9 store rdata", rdata, 0);
        end else begin
          chk({tag, " rdata"}, rdata, v.exp_rd);
          chk({tag, " load_ext"}, load_ext, v.exp_ext);
        end
      end
    end
    @(negedge clk);
    mem_en = 1'b0;
    #1;
    chk("R3 wrap", 32'(wait_cnt), 0);
    chk("R9 idle we", {we_hi, we_lo}, 0);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 cnt", 32'(wait_cnt), 0);
    chk("R1 ready", 32'(ready), 0);
    chk("R1 we", {we_hi, we_lo}, 0);
    rst = 1'b0;

    foreach (VEC[i]) access(VEC[i]);

    // R3: abandon at count 2 with a store pending
    @(negedge clk);
    mem_en = 1'b1; wr_sel = 1'b1; size_byte = 1'b0; addr = 16'h0010; wdata = 16'hDEAD;
    repeat (2) @(negedge clk);
    #1 chk("R3 mid count", 32'(wait_cnt), 2);
    @(negedge clk);
    mem_en = 1'b0;
    #1;
    chk("R9 en low we", {we_hi, we_lo}, 0);
    @(negedge clk); #1;
    chk("R3 abandon", 32'(wait_cnt), 0);
    chk("R3 abandon ready", 32'(ready), 0);
    // abandoned store left the word intact
    access('{1'b0, 1'b0, 16'h0010, 16'h0000, 16'hA581, 16'hA581, 4'd3});

    // R3: back-to-back with mem_en held high
    @(negedge clk);
    mem_en = 1'b1; wr_sel = 1'b0; size_byte = 1'b0; addr = 16'h0012;
    repeat (LAT) @(negedge clk);
    #1;
    chk("R3 restart cnt", 32'(wait_cnt), 0);
    chk("R3 restart ready", 32'(ready), 0);
    repeat (LAT-1) @(negedge clk);
    #1;
    chk("R2 second ready", 32'(ready), 1);
    chk("R8 second rdata", rdata, 16'hF034);
    @(negedge clk);
    mem_en = 1'b0;

    // R1: reset in mid-access
    @(negedge clk);
    mem_en = 1'b1; wr_sel = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    chk("R1 mid reset cnt", 32'(wait_cnt), 0);
    chk("R1 mid reset we", {we_hi, we_lo}, 0);
    rst = 1'b0; mem_en = 1'b0; wr_sel = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule